// File: doc/BRIEF.md
# Sampled Sliding-Surface Switch Controller

This block closes the loop around a half-bridge power stage that feeds a low-pass output filter. On each oversampling strobe it takes a signed reference sample and a signed sample of the filtered output voltage. It forms a tracking error and builds three chained first-difference derivatives of that error. From these it computes a third-order switching surface and turns it into a one-bit polarity command. The command keeps memory of the previous surface sign, which gives the decision a hysteresis band. The command drives a complementary pair of gate outputs, with a programmable gap during which both gates are low.

Software loads the gain, the three surface weights, the hysteresis width, the derivative scale and the gate gap while the block is disabled. All arithmetic uses signed Q8.8 coefficients. Each intermediate value saturates to the sample width. For stability the weights are normally set from a third-order Bessel polynomial in the response time tr: weight 1 is tr, weight 2 is 6·tr²/15 and weight 3 is tr³/15.

Top module: `smc_switch_ctrl`

## Requirements
- R1: On an enabled strobe the error is `ref_in - ((vout_in * gain) >>> 8)`, saturated to the sample width, where gain is a signed Q8.8 value. With all weights zero, `surf_o` equals this error after the strobe's clock edge.
- R2: The derivatives chain as follows: d1 = sat(((err - err_prev) * ratio) >>> 8), d2 is the same operation on d1 and d1_prev, and d3 the same on d2 and d2_prev. The surface is sat(err + ((w1*d1 + w2*d2 + w3*d3) >>> 8)), and every coefficient is signed Q8.8.
- R3: Every stage saturates to the signed range of the sample width, which is [-32768, 32767] at the default width. It does not wrap.
- R4: After warm-up, an enabled strobe sets `cmd_pos` to 1 when surf + eps·sgn(previous surf) is ≥ 0, and to 0 otherwise. Here sgn(x) is +1 for x ≥ 0 and -1 for x < 0. `cmd_pos` = 1 means the upper switch is on, and 0 means the lower switch is on.
- R5: During reset and on leaving it, `surf_o`, `cmd_pos`, `gate_hi` and `gate_lo` are 0. The derivative history is zero, and the stored previous sign is +1.
- R6: On the first three enabled strobes after reset, `cmd_pos` stays 0.
- R7: `gate_hi` is high only while the command is 1 and `gate_lo` only while it is 0. The two are never high together, and both are low while `en` is 0.
- R8: After every change of the command, both gates stay low for exactly `guard` clock cycles before the new gate rises.
- R9: Configuration writes take effect only while `en` is 0. The address map is 0 gain, 1 w1, 2 w2, 3 w3, 4 eps, 5 ratio, 6 guard. On reset, gain and ratio are 1.0 (256), guard is 1, and the others are 0.
- R10: A strobe while `en` is 0 changes neither `surf_o` nor `cmd_pos`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; also locks the configuration |
| strobe | input | 1 | One-cycle oversampling strobe |
| ref_in | input | DW | Signed reference sample |
| vout_in | input | DW | Signed filter output sample |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | CW | Configuration write data |
| surf_o | output | DW | Registered surface value of the last strobe |
| cmd_pos | output | 1 | Switch command, 1 upper on, 0 lower on |
| gate_hi | output | 1 | Upper switch gate |
| gate_lo | output | 1 | Lower switch gate |

## Verification
Some properties are checked on every cycle:
- the gates are mutually exclusive and each follows the command polarity;
- both gates are low in the cycle after a command change;
- the command is held low through warm-up;
- the surface and command stay frozen without an enabled strobe;
- the configuration stays frozen while running.

Other properties only the bench scenarios can show. These are:
- the numerical value of the surface under ramp and step references;
- saturation at both rails;
- the hysteresis memory, including the zero-surface sign convention;
- the exact length of the gate gap.

The bench shows these by comparing against an integer model.

// File: rtl/smc_pkg.sv
package smc_pkg;

  // Configuration register map
  typedef enum logic [2:0] {
    CFG_GAIN  = 3'd0,
    CFG_W1    = 3'd1,
    CFG_W2    = 3'd2,
    CFG_W3    = 3'd3,
    CFG_EPS   = 3'd4,
    CFG_RATIO = 3'd5,
    CFG_GUARD = 3'd6
  } cfg_addr_e;

  localparam int unsigned NUM_COEF      = 6;
  localparam int unsigned DEF_WARMUP    = 3;

endpackage

// File: rtl/smc_cfg_regs.sv
module smc_cfg_regs
  import smc_pkg::*;
#(
  parameter int unsigned CW   = 16,
  parameter int unsigned GW   = 8,
  parameter int unsigned FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 we,
  input  logic [2:0]           addr,
  input  logic [CW-1:0]        wdata,
  output logic signed [CW-1:0] gain,
  output logic signed [CW-1:0] w1,
  output logic signed [CW-1:0] w2,
  output logic signed [CW-1:0] w3,
  output logic signed [CW-1:0] eps,
  output logic signed [CW-1:0] ratio,
  output logic [GW-1:0]        guard
);

  localparam logic signed [CW-1:0] UNITY = CW'(1) << FRAC;

  logic signed [CW-1:0] coef_q [NUM_COEF];

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    localparam logic signed [CW-1:0] RST_V =
      ((i == int'(CFG_GAIN)) || (i == int'(CFG_RATIO))) ? UNITY : '0;
    logic                 wr_en;
    logic signed [CW-1:0] coef_n;

    assign wr_en = we & ~en & (addr == 3'(i));

    always_comb begin
      coef_n = coef_q[i];
      if (wr_en) coef_n = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) coef_q[i] <= RST_V;
      else        coef_q[i] <= coef_n;
    end
  end

  logic          guard_wr;
  logic [GW-1:0] guard_n;
  logic [GW-1:0] guard_q;

  assign guard_wr = we & ~en & (addr == CFG_GUARD);

  always_comb begin
    guard_n = guard_q;
    if (guard_wr) guard_n = wdata[GW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) guard_q <= GW'(1);
    else        guard_q <= guard_n;
  end

  assign gain  = coef_q[int'(CFG_GAIN)];
  assign w1    = coef_q[int'(CFG_W1)];
  assign w2    = coef_q[int'(CFG_W2)];
  assign w3    = coef_q[int'(CFG_W3)];
  assign eps   = coef_q[int'(CFG_EPS)];
  assign ratio = coef_q[int'(CFG_RATIO)];
  assign guard = guard_q;

endmodule

// File: rtl/smc_surface.sv
module smc_surface #(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic signed [DW-1:0] ref_in,
  input  logic signed [DW-1:0] vout_in,
  input  logic signed [CW-1:0] gain,
  input  logic signed [CW-1:0] ratio,
  input  logic signed [CW-1:0] w1,
  input  logic signed [CW-1:0] w2,
  input  logic signed [CW-1:0] w3,
  output logic signed [DW-1:0] surf_now,
  output logic signed [DW-1:0] surf_q
);

  localparam int unsigned WW = DW + CW + 4;
  typedef logic signed [WW-1:0] wide_t;
  localparam wide_t MAXW = {{(WW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam wide_t MINW = ~MAXW;

  function automatic logic signed [DW-1:0] clip(input wide_t x);
    if (x > MAXW)      return MAXW[DW-1:0];
    else if (x < MINW) return MINW[DW-1:0];
    else               return x[DW-1:0];
  endfunction

  function automatic wide_t xs(input logic signed [DW-1:0] v);
    return wide_t'(v);
  endfunction

  function automatic wide_t xc(input logic signed [CW-1:0] v);
    return wide_t'(v);
  endfunction

  function automatic logic signed [DW-1:0] slope(
    input logic signed [DW-1:0] cur,
    input logic signed [DW-1:0] prv,
    input logic signed [CW-1:0] scl
  );
    wide_t d;
    wide_t p;
    d = xs(cur) - xs(prv);
    p = d * xc(scl);
    return clip(p >>> FRAC);
  endfunction

  logic signed [DW-1:0] err_z_q, d1_z_q, d2_z_q;
  logic signed [DW-1:0] err_z_n, d1_z_n, d2_z_n, surf_n;
  logic signed [DW-1:0] err_c, d1_c, d2_c, d3_c;
  wide_t                prod_g, acc;

  always_comb begin
    prod_g   = xs(vout_in) * xc(gain);
    err_c    = clip(xs(ref_in) - (prod_g >>> FRAC));
    d1_c     = slope(err_c, err_z_q, ratio);
    d2_c     = slope(d1_c,  d1_z_q,  ratio);
    d3_c     = slope(d2_c,  d2_z_q,  ratio);
    acc      = xc(w1) * xs(d1_c) + xc(w2) * xs(d2_c) + xc(w3) * xs(d3_c);
    surf_now = clip(xs(err_c) + (acc >>> FRAC));
  end

  always_comb begin
    err_z_n = err_z_q;
    d1_z_n  = d1_z_q;
    d2_z_n  = d2_z_q;
    surf_n  = surf_q;
    if (step) begin
      err_z_n = err_c;
      d1_z_n  = d1_c;
      d2_z_n  = d2_c;
      surf_n  = surf_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_z_q <= '0;
      d1_z_q  <= '0;
      d2_z_q  <= '0;
      surf_q  <= '0;
    end else begin
      err_z_q <= err_z_n;
      d1_z_q  <= d1_z_n;
      d2_z_q  <= d2_z_n;
      surf_q  <= surf_n;
    end
  end

endmodule

// File: rtl/smc_switch_law.sv
module smc_switch_law #(
  parameter int unsigned DW   = 16,
  parameter int unsigned WARM = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step,
  input  logic signed [DW-1:0] surf,
  input  logic signed [DW-1:0] eps,
  output logic                 cmd_pos
);

  localparam int unsigned WCW    = $clog2(WARM + 2);
  localparam logic [WCW-1:0] WARM_V = WCW'(WARM);

  logic                 prev_pos_q, prev_pos_n;
  logic [WCW-1:0]       warm_q, warm_n;
  logic                 cmd_q, cmd_n;
  logic                 warm_done, decide;
  logic signed [DW+1:0] s_x, e_x, band;

  always_comb begin
    s_x       = {{2{surf[DW-1]}}, surf};
    e_x       = {{2{eps[DW-1]}}, eps};
    band      = prev_pos_q ? (s_x + e_x) : (s_x - e_x);
    decide    = ~band[DW+1];
    warm_done = (warm_q == WARM_V);

    cmd_n      = cmd_q;
    warm_n     = warm_q;
    prev_pos_n = prev_pos_q;
    if (step) begin
      cmd_n      = warm_done & decide;
      prev_pos_n = ~surf[DW-1];
      if (!warm_done) warm_n = warm_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pos_q <= 1'b1;
      warm_q     <= '0;
      cmd_q      <= 1'b0;
    end else begin
      prev_pos_q <= prev_pos_n;
      warm_q     <= warm_n;
      cmd_q      <= cmd_n;
    end
  end

  assign cmd_pos = cmd_q;

endmodule

// File: rtl/smc_gate_drv.sv
module smc_gate_drv #(
  parameter int unsigned GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cmd_pos,
  input  logic [GW-1:0] guard,
  output logic          gate_hi,
  output logic          gate_lo
);

  logic          cmd_d_q;
  logic [GW-1:0] gap_q, gap_n;
  logic          hi_q, lo_q, hi_n, lo_n;
  logic          flip, clear;

  always_comb begin
    flip  = cmd_pos ^ cmd_d_q;
    gap_n = gap_q;
    if (flip)               gap_n = guard;
    else if (gap_q != '0)   gap_n = gap_q - 1'b1;
    clear = (gap_n == '0);
    hi_n  = en &  cmd_pos & clear;
    lo_n  = en & ~cmd_pos & clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_d_q <= 1'b0;
      gap_q   <= '0;
      hi_q    <= 1'b0;
      lo_q    <= 1'b0;
    end else begin
      cmd_d_q <= cmd_pos;
      gap_q   <= gap_n;
      hi_q    <= hi_n;
      lo_q    <= lo_n;
    end
  end

  assign gate_hi = hi_q;
  assign gate_lo = lo_q;

endmodule

// File: rtl/smc_switch_ctrl.sv
module smc_switch_ctrl
  import smc_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned CW     = 16,
  parameter int unsigned FRAC   = 8,
  parameter int unsigned GW     = 8,
  parameter int unsigned WARMUP = DEF_WARMUP
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 strobe,
  input  logic signed [DW-1:0] ref_in,
  input  logic signed [DW-1:0] vout_in,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [CW-1:0]        cfg_wdata,
  output logic signed [DW-1:0] surf_o,
  output logic                 cmd_pos,
  output logic                 gate_hi,
  output logic                 gate_lo
);

  logic rst_meta, rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_meta} <= 2'b00;
    else        {rst_s, rst_meta} <= {rst_meta, 1'b1};
  end

  logic signed [CW-1:0] gain_q, w1_q, w2_q, w3_q, eps_q, ratio_q;
  logic [GW-1:0]        guard_q;
  logic signed [DW-1:0] surf_now;
  logic                 step;

  assign step = strobe & en;

  smc_cfg_regs #(.CW(CW), .GW(GW), .FRAC(FRAC)) u_regs (
    .clk   (clk),
    .rst_n (rst_s),
    .en    (en),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .gain  (gain_q),
    .w1    (w1_q),
    .w2    (w2_q),
    .w3    (w3_q),
    .eps   (eps_q),
    .ratio (ratio_q),
    .guard (guard_q)
  );

  smc_surface #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_surf (
    .clk      (clk),
    .rst_n    (rst_s),
    .step     (step),
    .ref_in   (ref_in),
    .vout_in  (vout_in),
    .gain     (gain_q),
    .ratio    (ratio_q),
    .w1       (w1_q),
    .w2       (w2_q),
    .w3       (w3_q),
    .surf_now (surf_now),
    .surf_q   (surf_o)
  );

  smc_switch_law #(.DW(DW), .WARM(WARMUP)) u_law (
    .clk     (clk),
    .rst_n   (rst_s),
    .step    (step),
    .surf    (surf_now),
    .eps     (eps_q[DW-1:0]),
    .cmd_pos (cmd_pos)
  );

  smc_gate_drv #(.GW(GW)) u_gate (
    .clk     (clk),
    .rst_n   (rst_s),
    .en      (en),
    .cmd_pos (cmd_pos),
    .guard   (guard_q),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
  );

endmodule

// File: rtl/smc_switch_ctrl_chk.sv
module smc_switch_ctrl_chk #(
  parameter int unsigned DW     = 16,
  parameter int unsigned CW     = 16,
  parameter int unsigned GW     = 8,
  parameter int unsigned WARMUP = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 strobe,
  input logic                 cmd_pos,
  input logic                 gate_hi,
  input logic                 gate_lo,
  input logic signed [DW-1:0] surf_o,
  input logic [GW-1:0]        guard,
  input logic [6*CW+GW-1:0]   cfg_flat
);

  logic [7:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                seen_q <= '0;
    else if (strobe && en && seen_q != 8'hFF)  seen_q <= seen_q + 8'd1;
  end

  // R7
  gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R7
  gate_hi_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi |-> $past(cmd_pos));

  // R7
  gate_lo_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo |-> !$past(cmd_pos));

  // R8
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_pos != $past(cmd_pos)) && (guard != '0)) |=> (!gate_hi && !gate_lo));

  // R6
  warmup_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q <= 8'(WARMUP)) |-> !cmd_pos);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe && en) |=> ($stable(surf_o) && $stable(cmd_pos)));

  // R9
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(cfg_flat));

endmodule

bind smc_switch_ctrl smc_switch_ctrl_chk #(
  .DW(DW), .CW(CW), .GW(GW), .WARMUP(WARMUP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_s),
  .en       (en),
  .strobe   (strobe),
  .cmd_pos  (cmd_pos),
  .gate_hi  (gate_hi),
  .gate_lo  (gate_lo),
  .surf_o   (surf_o),
  .guard    (guard_q),
  .cfg_flat ({gain_q, w1_q, w2_q, w3_q, eps_q, ratio_q, guard_q})
);

// File: tb/smc_switch_ctrl_tb.sv
`timescale 1ns/1ps
module smc_switch_ctrl_tb;

  localparam int DW = 16;
  localparam int CW = 16;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 en, strobe, cfg_we;
  logic signed [DW-1:0] ref_in, vout_in;
  logic [2:0]           cfg_addr;
  logic [CW-1:0]        cfg_wdata;
  logic signed [DW-1:0] surf_o;
  logic                 cmd_pos, gate_hi, gate_lo;

  always #2.5 clk = ~clk;

  smc_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .strobe(strobe),
    .ref_in(ref_in), .vout_in(vout_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .surf_o(surf_o),
    .cmd_pos(cmd_pos), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // columns: ref, vout, expected surface (gain 2.0, weights 0), saturating case
  localparam int VEC [8][4] = '{
    '{100,     20,     60,     0},
    '{-50,     10,    -70,     0},
    '{0,       0,      0,      0},
    '{1000,   -200,    1400,   0},
    '{30000,  -10000,  32767,  1},
    '{-30000,  10000, -32768,  1},
    '{5,       3,     -1,      0},
    '{7,       3,      1,      0}
  };

  // behavioural model state
  longint m_gain, m_w1, m_w2, m_w3, m_eps, m_ratio;
  longint m_ez, m_d1z, m_d2z;
  bit     m_prev;
  int     m_warm;

  function automatic longint clip16(input longint x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic model_clear();
    m_ez = 0; m_d1z = 0; m_d2z = 0; m_prev = 1'b1; m_warm = 0;
  endtask

  task automatic model_step(input longint r, input longint v,
                            output longint s, output bit pos);
    longint e, d1, d2, d3, acc, h;
    e   = clip16(r - ((v * m_gain) >>> 8));
    d1  = clip16(((e  - m_ez)  * m_ratio) >>> 8);
    d2  = clip16(((d1 - m_d1z) * m_ratio) >>> 8);
    d3  = clip16(((d2 - m_d2z) * m_ratio) >>> 8);
    acc = m_w1 * d1 + m_w2 * d2 + m_w3 * d3;
    s   = clip16(e + (acc >>> 8));
    h   = s + (m_prev ? m_eps : -m_eps);
    pos = (m_warm >= 3) && (h >= 0);
    m_prev = (s >= 0);
    if (m_warm < 3) m_warm++;
    m_ez = e; m_d1z = d1; m_d2z = d2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 0; strobe = 0; cfg_we = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  task automatic cfg_write(input logic [2:0] a, input int d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = CW'(d);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_strobe(input int r, input int v);
    @(negedge clk);
    ref_in = DW'(r); vout_in = DW'(v); strobe = 1;
    @(negedge clk);
    strobe = 0;
  endtask

  task automatic load_cfg(input int g, input int a, input int b, input int c,
                          input int e, input int rt, input int gd);
    cfg_write(3'd0, g);  cfg_write(3'd1, a); cfg_write(3'd2, b);
    cfg_write(3'd3, c);  cfg_write(3'd4, e); cfg_write(3'd5, rt);
    cfg_write(3'd6, gd);
    m_gain = g; m_w1 = a; m_w2 = b; m_w3 = c; m_eps = e; m_ratio = rt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    ref_in = 0; vout_in = 0; cfg_addr = 0; cfg_wdata = 0;
    en = 0; strobe = 0; cfg_we = 0; rst_n = 0;

    // R5: reset state
    do_reset();
    check("R5 surf", surf_o, 0);
    check("R5 cmd", cmd_pos, 0);
    check("R5 gate_hi", gate_hi, 0);
    check("R5 gate_lo", gate_lo, 0);

    // Table walk: gain 2.0, weights zero, eps zero, guard 3
    load_cfg(512, 0, 0, 0, 0, 256, 3);
    @(negedge clk); en = 1;
    for (int i = 0; i < 8; i++) begin
      do_strobe(VEC[i][0], VEC[i][1]);
      if (VEC[i][3] != 0) check("R3 saturated surface", surf_o, VEC[i][2]);
      else                check("R1 error surface", surf_o, VEC[i][2]);
      if (i < 3) check("R6 warm-up command", cmd_pos, 0);
      else       check("R4 command sign", cmd_pos, (VEC[i][2] >= 0) ? 1 : 0);
    end
    repeat (6) @(negedge clk);
    check("R7 gate_hi for +1", gate_hi, 1);
    check("R7 gate_lo for +1", gate_lo, 0);

    // R8: dead gap on a falling command
    do_strobe(-100, 0);
    check("R4 command falls", cmd_pos, 0);
    begin
      int lows = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!gate_hi && !gate_lo) lows++;
        else break;
      end
      check("R8 gap cycles", lows, 3);
      check("R7 gate_lo after gap", gate_lo, 1);
      check("R7 gate_hi after gap", gate_hi, 0);
    end

    // R9: write while running is ignored (w1 would change the surface)
    cfg_write(3'd1, 1000);
    do_strobe(200, 0);
    check("R9 write ignored while en", surf_o, 200);
    check("R4 command rises", cmd_pos, 1);

    // R10: strobe while disabled is ignored
    @(negedge clk); en = 0;
    do_strobe(-500, 0);
    check("R10 surf held", surf_o, 200);
    check("R10 cmd held", cmd_pos, 1);
    check("R7 gates low when disabled", gate_hi | gate_lo, 0);

    // R4 hysteresis with eps 100 and sgn(0)=+1
    do_reset();
    load_cfg(256, 0, 0, 0, 100, 256, 1);
    @(negedge clk); en = 1;
    for (int i = 0; i < 3; i++) begin
      do_strobe(500, 0);
      check("R6 warm-up command", cmd_pos, 0);
    end
    do_strobe(-50, 0);  check("R4 inside band, prev +", cmd_pos, 1);
    do_strobe(-50, 0);  check("R4 prev -", cmd_pos, 0);
    do_strobe(60, 0);   check("R4 inside band, prev -", cmd_pos, 0);
    do_strobe(150, 0);  check("R4 beyond band", cmd_pos, 1);
    do_strobe(-50, 0);  check("R4 band again", cmd_pos, 1);
    do_strobe(0, 0);    check("R4 zero surf, prev -", cmd_pos, 0);
    do_strobe(-99, 0);  check("R4 zero counts as +", cmd_pos, 1);

    // R2: ramp then step against the integer model, Bessel-like weights
    do_reset();
    load_cfg(256, 768, 922, 461, 40, 384, 2);
    @(negedge clk); en = 1;
    for (int i = 0; i < 40; i++) begin
      int r, v;
      longint es;
      bit ep;
      if (i < 20) begin r = 150 * i; v = 140 * i + (i % 3) * 7; end
      else        begin r = 8000;    v = 3000 + 200 * (i - 20); end
      model_step(r, v, es, ep);
      do_strobe(r, v);
      check("R2 surface model", surf_o, es);
      check("R4 command model", cmd_pos, ep);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule